// File: doc/BRIEF.md
# System control coprocessor registers

This block holds the privileged control state of a 32-bit RISC core. It contains a status word with a three-level stack of kernel and interrupt-enable flags, a cause word, an exception program counter (EPC) and a fixed processor identifier. The core hands it each coprocessor instruction word together with the value of the source register. The block decodes move-to, move-from and return-from-exception from that word. The move-from result is combinational and appears in the same cycle.

Up to eight hardware interrupt lines are registered on every clock and gated one by one by the interrupt-mask field of status. A line that passes its mask, or a system-call strobe from the core, raises an exception request with a cause code. The block accepts the exception entry on the following clock edge. At that edge it pushes the flag stack, captures the faulting address into EPC and records the code in cause. Exception entry takes priority over any coprocessor operation that arrives in the same cycle.

Top module: `sysctl_cop`

## Requirements
- R1: A move-to of register 12 stores the source value ANDed with 0x0003FF3F. No status bit outside that mask is ever set.
- R2: A move-from of register 12 returns the status value ANDed with 0x0000FF3F.
- R3: A move-from returns cause for register 13, EPC for register 14 and the PROC_ID parameter for register 15. Every other register number reads as zero. A move-to of any register other than 12 changes nothing.
- R4: A coprocessor word is one whose bits [31:26] equal 6'b010000. When status bit 1 (kernel) is clear, such a word has no effect, op_denied is 1 and rd_data is 0.
- R5: In kernel mode the word 0x42000010 (return from exception) copies status bits [5:2] into bits [3:0] and leaves bits [31:4] unchanged. For any other coprocessor word, bit 23 set means move-to and bit 23 clear means move-from, and bits [15:11] give the register number.
- R6: Interrupt line i is registered once per clock. Its registered value raises exc_req with exc_code 0 only while status bit 8+i is set, one cycle after the line goes high at the input. A masked line never raises exc_req.
- R7: A sys_call strobe raises exc_req with exc_code 8 in the same cycle. When an unmasked interrupt and sys_call coincide, exc_code is 0.
- R8: On the clock edge where exc_req is 1, three updates happen together. Status bits [5:0] become {bits[3:0], 2'b10}, which means kernel mode with interrupts disabled. EPC takes fault_pc. Cause becomes the code in bits [6:2] with all other bits zero.
- R9: When exc_req and a move-to or return-from-exception fall in the same cycle, only the exception entry updates status.
- R10: After reset, status reads 0x00000002 and cause and EPC read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | op_word carries an instruction this cycle |
| op_word | input | 32 | Instruction word |
| wr_data | input | 32 | Source register value for a move-to |
| rd_data | output | 32 | Move-from result, zero when no move-from is allowed |
| op_denied | output | 1 | Coprocessor word refused outside kernel mode |
| irq_in | input | NIRQ | Hardware interrupt lines |
| sys_call | input | 1 | System-call instruction strobe |
| fault_pc | input | 32 | Address of the instruction taking the exception |
| exc_req | output | 1 | Exception requested this cycle |
| exc_code | output | 5 | Cause code of the request |

## Verification
Exception entry can meet a move-to of status in the same cycle, and a gated interrupt can meet a system call in the same cycle. The bench provokes the first case by asserting sys_call and presenting a move-to of 0 to register 12 at the same falling edge. It then reads status back and expects the pushed flag stack with the old upper bits, not zero. For the second case it raises an enabled interrupt line one cycle before sys_call and expects exc_code 0 during the overlap and a cause of 0 afterwards.

// File: rtl/sysctl_cop.sv
module sysctl_cop #(
  parameter int NIRQ = 8,
  parameter logic [31:0] PROC_ID = 32'h0000_0230
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [31:0]     op_word,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            op_denied,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            sys_call,
  input  logic [31:0]     fault_pc,
  output logic            exc_req,
  output logic [4:0]      exc_code
);
  localparam logic [31:0] IM_BITS  = ((32'd1 << NIRQ) - 32'd1) << 8;
  localparam logic [31:0] WR_MASK  = 32'h0003_003F | IM_BITS;
  localparam logic [31:0] RD_MASK  = 32'h0000_003F | IM_BITS;
  localparam logic [31:0] RFE_WORD = 32'h4200_0010;
  localparam logic [4:0]  CODE_IRQ = 5'd0;
  localparam logic [4:0]  CODE_SYS = 5'd8;

  logic [31:0]     status_q, cause_q, epc_q;
  logic [NIRQ-1:0] irq_q;

  wire       is_cop = op_valid && (op_word[31:26] == 6'b010000);
  wire       is_rfe = is_cop && (op_word == RFE_WORD);
  wire       is_mtc = is_cop && !is_rfe && op_word[23];
  wire       is_mfc = is_cop && !is_rfe && !op_word[23];
  wire       kernel = status_q[1];
  wire [4:0] regno  = op_word[15:11];
  wire       irq_hit = |(irq_q & status_q[8 +: NIRQ]);

  assign op_denied = is_cop && !kernel;
  assign exc_req   = irq_hit || sys_call;
  assign exc_code  = irq_hit ? CODE_IRQ : CODE_SYS;

  always_comb begin
    rd_data = '0;
    if (is_mfc && kernel) begin
      case (regno)
        5'd12:   rd_data = status_q & RD_MASK;
        5'd13:   rd_data = cause_q;
        5'd14:   rd_data = epc_q;
        5'd15:   rd_data = PROC_ID;
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 32'h0000_0002;
      cause_q  <= '0;
      epc_q    <= '0;
      irq_q    <= '0;
    end else begin
      irq_q <= irq_in;
      if (exc_req) begin
        status_q[5:0] <= {status_q[3:0], 2'b10};
        epc_q         <= fault_pc;
        cause_q       <= {25'd0, exc_code, 2'b00};
      end else if (kernel) begin
        if (is_rfe)
          status_q[3:0] <= status_q[5:2];
        else if (is_mtc && regno == 5'd12)
          status_q <= wr_data & WR_MASK;
      end
    end
  end
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [31:0]     op_word,
  input logic [31:0]     rd_data,
  input logic            op_denied,
  input logic            sys_call,
  input logic [31:0]     fault_pc,
  input logic            exc_req,
  input logic [31:0]     status_q,
  input logic [31:0]     epc_q,
  input logic [NIRQ-1:0] irq_q
);
  wire cop    = op_valid && op_word[31:26] == 6'b010000;
  wire rfe    = cop && op_word == 32'h4200_0010;
  wire mtc12  = cop && !rfe && op_word[23] && op_word[15:11] == 5'd12;
  wire mfc12  = cop && !rfe && !op_word[23] && op_word[15:11] == 5'd12;

  assert_write_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (status_q & ~(32'h0003_003F | (((32'd1 << NIRQ) - 32'd1) << 8))) == 32'd0);

  assert_read_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mfc12 |-> (rd_data & ~32'h0000_FF3F) == 32'd0);

  assert_user_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cop && !status_q[1] |-> op_denied && rd_data == 32'd0);

  assert_user_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cop && !status_q[1] && !exc_req |=> status_q == $past(status_q));

  assert_rfe_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rfe && status_q[1] && !exc_req |=>
      status_q[3:0] == $past(status_q[5:2]) && status_q[31:4] == $past(status_q[31:4]));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & status_q[8 +: NIRQ]) == '0 && !sys_call |-> !exc_req);

  assert_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> epc_q == $past(fault_pc) && status_q[5:0] == {$past(status_q[3:0]), 2'b10});

  assert_entry_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && (mtc12 || rfe) |=> status_q[31:6] == $past(status_q[31:6]));
endmodule

bind sysctl_cop sysctl_cop_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
  .rd_data(rd_data), .op_denied(op_denied), .sys_call(sys_call),
  .fault_pc(fault_pc), .exc_req(exc_req), .status_q(status_q),
  .epc_q(epc_q), .irq_q(irq_q)
);

// File: tb/sysctl_cop_tb.sv
module sysctl_cop_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h0000_0230;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_word = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        op_denied;
  logic [7:0]  irq_in = '0;
  logic        sys_call = 1'b0;
  logic [31:0] fault_pc = '0;
  logic        exc_req;
  logic [4:0]  exc_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_cop #(.NIRQ(8), .PROC_ID(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .wr_data(wr_data), .rd_data(rd_data), .op_denied(op_denied),
    .irq_in(irq_in), .sys_call(sys_call), .fault_pc(fault_pc),
    .exc_req(exc_req), .exc_code(exc_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] r, output logic [31:0] v);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = {6'b010000, 5'b00000, 5'd0, r, 11'd0};
    #1 v = rd_data;
    op_valid = 1'b0;
  endtask

  task automatic mtc(input logic [4:0] r, input logic [31:0] d);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = {6'b010000, 5'b00100, 5'd0, r, 11'd0};
    wr_data  = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rfe();
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = 32'h4200_0010;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic syscall(input logic [31:0] pc);
    @(negedge clk);
    sys_call = 1'b1;
    fault_pc = pc;
    #1;
    chk("R7 exc_req", {31'd0, exc_req}, 32'd1);
    chk("R7 exc_code", {27'd0, exc_code}, 32'd8);
    @(negedge clk);
    sys_call = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd12, v); chk("R10 status", v, 32'h2);
    rd(5'd13, v); chk("R10 cause", v, 32'h0);
    rd(5'd14, v); chk("R10 epc", v, 32'h0);
    rd(5'd15, v); chk("R3 id", v, ID);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    mtc(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R1 R2 status masks", v, 32'h0000_FF3F);
    mtc(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R3 cause not writable", v, 32'h0);
    rd(5'd3, v);  chk("R3 unused reg", v, 32'h0);
  endtask

  task automatic t_denied();
    logic [31:0] v;
    mtc(5'd12, 32'h0);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = {6'b010000, 5'b00100, 5'd0, 5'd12, 11'd0};
    wr_data  = 32'h0000_FF02;
    #1 chk("R4 op_denied", {31'd0, op_denied}, 32'd1);
    @(negedge clk);
    op_valid = 1'b0;
    rd(5'd15, v); chk("R4 read in user", v, 32'h0);
    syscall(32'h0000_0100);
    rd(5'd12, v); chk("R4 write refused", v, 32'h2);
    rd(5'd14, v); chk("R8 epc", v, 32'h100);
  endtask

  task automatic t_rfe();
    logic [31:0] v;
    mtc(5'd12, 32'h0000_003E);
    rfe();
    rd(5'd12, v); chk("R5 rfe pop", v, 32'h0000_003F);
    mtc(5'd12, 32'h0000_A536);
    rfe();
    syscall(32'h0000_2000);
    rd(5'd12, v); chk("R5 R8 upper kept, push", v, 32'h0000_A536);
    rd(5'd13, v); chk("R8 cause sys", v, 32'h20);
    rd(5'd14, v); chk("R8 epc sys", v, 32'h2000);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bit seen = 1'b0;
    @(negedge clk);
    irq_in = 8'h02;
    repeat (3) begin
      @(negedge clk);
      #1 if (exc_req) seen = 1'b1;
    end
    chk("R6 masked line quiet", {31'd0, seen}, 32'd0);
    irq_in = 8'h01;
    fault_pc = 32'h0000_3000;
    #1 chk("R6 one cycle latency", {31'd0, exc_req}, 32'd0);
    @(negedge clk);
    #1;
    chk("R6 exc_req", {31'd0, exc_req}, 32'd1);
    chk("R6 exc_code", {27'd0, exc_code}, 32'd0);
    irq_in = 8'h00;
    rd(5'd13, v); chk("R6 cause irq", v, 32'h0);
    rd(5'd14, v); chk("R8 epc irq", v, 32'h3000);
    rd(5'd12, v); chk("R8 status push", v, 32'h0000_A51A);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    @(negedge clk);
    sys_call = 1'b1;
    fault_pc = 32'h0000_4000;
    op_valid = 1'b1;
    op_word  = {6'b010000, 5'b00100, 5'd0, 5'd12, 11'd0};
    wr_data  = 32'h0;
    @(negedge clk);
    sys_call = 1'b0;
    op_valid = 1'b0;
    rd(5'd12, v); chk("R9 entry beats write", v, 32'h0000_A52A);
    rd(5'd14, v); chk("R9 epc", v, 32'h4000);
    @(negedge clk);
    irq_in = 8'h04;
    @(negedge clk);
    sys_call = 1'b1;
    #1 chk("R7 irq beats syscall", {27'd0, exc_code}, 32'd0);
    irq_in = 8'h00;
    @(negedge clk);
    sys_call = 1'b0;
    rd(5'd13, v); chk("R7 cause after overlap", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_denied();
    t_rfe();
    t_irq();
    t_prio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule